// File: doc/BRIEF.md
# SDRAM Command Bus Monitor

This block watches the command pins of a single-rank SDRAM interface on every rising clock edge. For each edge it names the command the pins form, reports the bank and the address field that matter for that command, and checks the command against a per-bank model. Each bank is closed, open (with its row held) or closing after an access with auto-precharge. An order that the device would not accept raises an error pulse with a reason code. Examples are an access to a closed bank, opening a bank that is already open, or a mode load or refresh while any bank is still open or closing.

The monitor is passive. It sits beside a memory controller or on a bench, and its results appear one clock after the edge that sampled the pins. Only the order of commands is checked. Minimum spacing between commands is not checked, and data is not modelled. The one timing rule it keeps is the auto-precharge delay, set by a parameter.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only when `cke` was high at the previous sampling edge and is high at the current one. Otherwise `cmd_valid` is 0 and every other output is 0 in the next cycle. When a command is decoded, `cmd_valid` is 1 in the cycle after the sampling edge. `cke` is taken as 0 across reset.
- R2: With `cs_n` high (deselect), or with `cs_n` low and `ras_n`/`cas_n`/`we_n` = 1/1/1, the result is code 0 (no operation) with no error and no change to any bank. `cmd_bank` always echoes `ba` for a decoded command.
- R3: With `cs_n` low, the codes are as follows. `ras_n`/`cas_n`/`we_n` = 1/1/0 is burst stop (1). 1/0/1 is read (2, or 3 with auto-precharge). 1/0/0 is write (4, or 5 with auto-precharge). 0/1/1 is activate (6). 0/1/0 is precharge (7 for one bank, 8 for all banks). 0/0/0 is mode load (9). The remaining pattern, 0/0/1, is refresh (10).
- R4: On read and write, `addr[10]` high selects the auto-precharge code. `cmd_addr` carries the column `addr[8:0]` with bits 11:9 cleared. For a legal access, `cmd_row` carries the row open in that bank; otherwise `cmd_row` is 0.
- R5: Activate reports `addr[11:0]` on `cmd_addr` as the row and opens a closed bank with that row. Activate to a bank that is open or closing gives error code 2 and leaves the bank and its row unchanged.
- R6: Any read or write, with or without auto-precharge, to a bank that is not open gives error code 1 and changes no bank.
- R7: A legal access with auto-precharge puts the bank in the closing state. If the access is sampled at edge E0, an activate sampled at edge E0+AP_DELAY still gets error 2, and one sampled at E0+AP_DELAY+1 is legal.
- R8: Precharge with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes every bank whatever `ba` holds. Both report `cmd_addr` 0 and never raise an error.
- R9: Mode load reports `addr` on `cmd_addr`. While any bank is open or closing it gives error 3. Otherwise it gives error 4 when `ba`, `addr[11]` or `addr[10]` is nonzero. Error 3 takes priority.
- R10: Refresh while any bank is open or closing gives error 5. Burst stop, no operation and refresh report `cmd_addr` 0.
- R11: `err_pulse` is high for exactly the decoded commands that break a rule, one cycle each. `err_code` is 0 whenever `err_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Address pins A11..A0 |
| cmd_valid | output | 1 | A command was decoded at the last edge |
| cmd_code | output | 4 | Command code (R3) |
| cmd_bank | output | 2 | Bank address of the command |
| cmd_addr | output | 12 | Row, column or mode field |
| cmd_row | output | 12 | Open row used by a legal access |
| err_pulse | output | 1 | Rule broken by the decoded command |
| err_code | output | 3 | Reason: 1 closed access, 2 busy activate, 3 mode while busy, 4 mode field, 5 refresh while busy |

## Verification
The bench targets the edge of the auto-precharge window, issuing activates one edge before and at the edge the bank becomes free. A design with an off-by-one counter would accept the first or reject the second. It drops `cke` for a single edge and then raises it. A monitor that looks only at the current `cke` would decode the second command and open bank 0 early, which the later activate would expose. An illegal activate is followed by a write, so a design that overwrote the row would report the wrong `cmd_row`. Precharge-all is issued with a nonzero-looking address and bank zero, so a design that closed only `ba` would let a later read to bank 2 pass. Mode loads with stray `addr[10]` or bank bits, and one while a bank is still closing, catch a decoder that forgets the busy or field rules or ranks them in the wrong order.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_BST  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_RDA  = 4'd3,
    CMD_WR   = 4'd4,
    CMD_WRA  = 4'd5,
    CMD_ACT  = 4'd6,
    CMD_PRE  = 4'd7,
    CMD_PALL = 4'd8,
    CMD_MRS  = 4'd9,
    CMD_REF  = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_ACC_CLOSED = 3'd1,
    ERR_ACT_BUSY   = 3'd2,
    ERR_MODE_BUSY  = 3'd3,
    ERR_MODE_FIELD = 3'd4,
    ERR_REF_BUSY   = 3'd5
  } err_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_CLOSING = 2'd2
  } bank_st_e;

  // Pin pattern to command name; a10 splits access and precharge variants.
  function automatic cmd_e pins_to_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n,
                                       input logic a10);
    if (cs_n) return CMD_NOP;
    case ({ras_n, cas_n, we_n})
      3'b111:  return CMD_NOP;
      3'b110:  return CMD_BST;
      3'b101:  return a10 ? CMD_RDA : CMD_RD;
      3'b100:  return a10 ? CMD_WRA : CMD_WR;
      3'b011:  return CMD_ACT;
      3'b010:  return a10 ? CMD_PALL : CMD_PRE;
      3'b000:  return CMD_MRS;
      default: return CMD_REF;
    endcase
  endfunction

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
  endfunction

  function automatic logic is_auto_close(input cmd_e c);
    return (c == CMD_RDA) || (c == CMD_WRA);
  endfunction

endpackage

// File: rtl/sdram_cmd_check.sv
module sdram_cmd_check
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBANK-1:0]  bank_open,
  input  logic [NBANK-1:0]  bank_idle,
  output cmd_e              cmd,
  output err_e              err
);

  logic any_busy;
  logic mode_field_bad;

  assign cmd            = pins_to_cmd(cs_n, ras_n, cas_n, we_n, addr[AP_BIT]);
  assign any_busy       = ~&bank_idle;
  assign mode_field_bad = (|ba) | addr[ADDR_W-1] | addr[AP_BIT];

  always_comb begin
    err = ERR_NONE;
    if (is_access(cmd)) begin
      if (!bank_open[ba]) err = ERR_ACC_CLOSED;
    end else begin
      case (cmd)
        CMD_ACT: if (!bank_idle[ba]) err = ERR_ACT_BUSY;
        CMD_MRS: begin
          if (any_busy)            err = ERR_MODE_BUSY;
          else if (mode_field_bad) err = ERR_MODE_FIELD;
        end
        CMD_REF: if (any_busy) err = ERR_REF_BUSY;
        default: err = ERR_NONE;
      endcase
    end
  end

  always_comb begin
    if (cmd == CMD_PALL || cmd == CMD_PRE || cmd == CMD_NOP || cmd == CMD_BST)
      assert_quiet_cmds_R8: assert (err == ERR_NONE);
  end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_mon_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int AP_DELAY = 4,
  localparam int CNT_W   = $clog2(AP_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             close_auto_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output bank_st_e         st_o,
  output logic [ROW_W-1:0] row_o
);

  logic [CNT_W-1:0] wait_cnt;
  logic             wait_done;

  assign wait_done = (wait_cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_o     <= BK_IDLE;
      row_o    <= '0;
      wait_cnt <= '0;
    end else if (pre_i) begin
      st_o     <= BK_IDLE;
      wait_cnt <= '0;
    end else if (act_i) begin
      st_o  <= BK_OPEN;
      row_o <= row_i;
    end else if (close_auto_i) begin
      st_o     <= BK_CLOSING;
      wait_cnt <= CNT_W'(AP_DELAY);
    end else if (st_o == BK_CLOSING) begin
      if (wait_done) begin
        st_o     <= BK_IDLE;
        wait_cnt <= '0;
      end else begin
        wait_cnt <= wait_cnt - CNT_W'(1);
      end
    end
  end

  assert_close_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o == BK_CLOSING && wait_cnt == CNT_W'(1)) |=> (st_o == BK_IDLE));

  assert_no_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o == BK_CLOSING) |=> (st_o != BK_OPEN));

  assert_act_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (st_o == BK_OPEN && row_o == $past(row_i)));

  assert_pre_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_i |=> (st_o == BK_IDLE));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int ADDR_W   = 12,
  parameter int COL_W    = 9,
  parameter int AP_BIT   = 10,
  parameter int AP_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_row,
  output logic              err_pulse,
  output logic [2:0]        err_code
);

  localparam int NBANK = 1 << BANK_W;

  // Address field reported for each command.
  function automatic logic [ADDR_W-1:0] field_of(input cmd_e c, input logic [ADDR_W-1:0] a);
    if (c == CMD_ACT || c == CMD_MRS) return a;
    if (is_access(c))                 return {{(ADDR_W-COL_W){1'b0}}, a[COL_W-1:0]};
    return '0;
  endfunction

  logic              cke_q;
  logic              sample_en;
  logic              cmd_legal;
  cmd_e              dec_cmd;
  err_e              dec_err;
  logic [NBANK-1:0]  bank_open;
  logic [NBANK-1:0]  bank_idle;
  logic [ADDR_W-1:0] bank_row [NBANK];

  assign sample_en = cke & cke_q;
  assign cmd_legal = sample_en && (dec_err == ERR_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  sdram_cmd_check #(
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT)
  ) i_check (
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .bank_open (bank_open),
    .bank_idle (bank_idle),
    .cmd       (dec_cmd),
    .err       (dec_err)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic     hit;
    logic     act_b;
    logic     auto_b;
    logic     pre_b;
    bank_st_e st_b;

    assign hit    = (ba == BANK_W'(b));
    assign act_b  = cmd_legal && hit && (dec_cmd == CMD_ACT);
    assign auto_b = cmd_legal && hit && is_auto_close(dec_cmd);
    assign pre_b  = cmd_legal && ((hit && dec_cmd == CMD_PRE) || dec_cmd == CMD_PALL);

    sdram_bank_fsm #(
      .ROW_W    (ADDR_W),
      .AP_DELAY (AP_DELAY)
    ) i_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .act_i        (act_b),
      .close_auto_i (auto_b),
      .pre_i        (pre_b),
      .row_i        (addr),
      .st_o         (st_b),
      .row_o        (bank_row[b])
    );

    assign bank_open[b] = (st_b == BK_OPEN);
    assign bank_idle[b] = (st_b == BK_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sample_en) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_row   <= '0;
      err_pulse <= 1'b0;
      err_code  <= '0;
    end else begin
      cmd_valid <= 1'b1;
      cmd_code  <= dec_cmd;
      cmd_bank  <= ba;
      cmd_addr  <= field_of(dec_cmd, addr);
      cmd_row   <= (cmd_legal && is_access(dec_cmd)) ? bank_row[ba] : '0;
      err_pulse <= (dec_err != ERR_NONE);
      err_code  <= dec_err;
    end
  end

  assert_gate_cke_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> !cmd_valid);

  assert_err_needs_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (cmd_valid && err_code != 3'd0));

  assert_act_leaves_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_ACT && !err_pulse) |-> bank_open[cmd_bank]);

  assert_mode_all_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_MRS && !err_pulse) |-> (&bank_idle));

  assert_pall_all_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_PALL) |-> (&bank_idle));

endmodule

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;

  typedef struct {
    logic        v;
    logic [3:0]  code;
    logic [1:0]  bank;
    logic [11:0] addr;
    logic [11:0] row;
    logic [2:0]  ecode;
    string       tag;
  } exp_t;

  localparam logic [3:0] P_NOP = 4'b0111, P_DESL = 4'b1111, P_BST = 4'b0110,
                         P_RD = 4'b0101, P_WR = 4'b0100, P_ACT = 4'b0011,
                         P_PRE = 4'b0010, P_MRS = 4'b0000, P_REF = 4'b0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic        cmd_valid, err_pulse;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr, cmd_row;
  logic [2:0]  err_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_row(cmd_row), .err_pulse(err_pulse),
    .err_code(err_code)
  );

  task automatic step(input logic cke_v, input logic [3:0] pins, input logic [1:0] b,
                      input logic [11:0] a, input logic ev, input logic [3:0] ec,
                      input logic [11:0] ea, input logic [11:0] er,
                      input logic [2:0] ee, input string tag);
    exp_t e;
    @(negedge clk);
    cke = cke_v;
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba = b;
    addr = a;
    e.v = ev; e.code = ec; e.bank = ev ? b : 2'd0;
    e.addr = ea; e.row = er; e.ecode = ee; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: results appear after the edge that sampled the pins.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if ({cmd_valid, cmd_code, cmd_bank, cmd_addr, cmd_row, err_pulse, err_code} !==
            {e.v, e.code, e.bank, e.addr, e.row, (e.ecode != 3'd0), e.ecode}) begin
          errors++;
          $display("FAIL %s: got v=%0b code=%0d bank=%0d addr=%h row=%h err=%0b/%0d exp v=%0b code=%0d bank=%0d addr=%h row=%h err=%0b/%0d",
                   e.tag, cmd_valid, cmd_code, cmd_bank, cmd_addr, cmd_row, err_pulse, err_code,
                   e.v, e.code, e.bank, e.addr, e.row, (e.ecode != 3'd0), e.ecode);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_valid !== 1'b0 || err_pulse !== 1'b0 || cmd_code !== 4'd0) begin
      errors++;
      $display("FAIL R11 reset: got v=%0b err=%0b code=%0d expected 0 0 0", cmd_valid, err_pulse, cmd_code);
    end
    rst_n = 1'b1;

    step(1, P_NOP, 0, 12'h000, 0, 0, 12'h000, 12'h000, 0, "R1 first edge after cke rises");
    step(1, P_NOP, 0, 12'h000, 1, 0, 12'h000, 12'h000, 0, "R2 nop");
    step(1, P_DESL, 3, 12'hFFF, 1, 0, 12'h000, 12'h000, 0, "R2 deselect");
    step(1, P_BST, 0, 12'h000, 1, 1, 12'h000, 12'h000, 0, "R3 burst stop");
    step(1, P_RD, 1, 12'h005, 1, 2, 12'h005, 12'h000, 1, "R6 read closed bank");
    step(1, P_ACT, 1, 12'hABC, 1, 6, 12'hABC, 12'h000, 0, "R5 activate");
    step(1, P_RD, 1, 12'h2FF, 1, 2, 12'h0FF, 12'hABC, 0, "R4 read column");
    step(1, P_ACT, 1, 12'h123, 1, 6, 12'h123, 12'h000, 2, "R5 activate busy");
    step(1, P_WR, 1, 12'h003, 1, 4, 12'h003, 12'hABC, 0, "R5 row kept");
    step(1, P_MRS, 0, 12'h000, 1, 9, 12'h000, 12'h000, 3, "R9 mode busy");
    step(1, P_REF, 0, 12'h000, 1, 10, 12'h000, 12'h000, 5, "R10 refresh busy");
    step(1, P_ACT, 2, 12'h055, 1, 6, 12'h055, 12'h000, 0, "R5 activate bank2");
    step(1, P_PRE, 1, 12'h000, 1, 7, 12'h000, 12'h000, 0, "R8 precharge one");
    step(1, P_RD, 1, 12'h000, 1, 2, 12'h000, 12'h000, 1, "R8 bank1 closed");
    step(1, P_RD, 2, 12'h007, 1, 2, 12'h007, 12'h055, 0, "R8 bank2 still open");
    step(1, P_PRE, 0, 12'h400, 1, 8, 12'h000, 12'h000, 0, "R8 precharge all");
    step(1, P_RD, 2, 12'h001, 1, 2, 12'h001, 12'h000, 1, "R8 bank2 closed by all");
    step(1, P_MRS, 0, 12'h033, 1, 9, 12'h033, 12'h000, 0, "R9 mode legal");
    step(1, P_MRS, 0, 12'h433, 1, 9, 12'h433, 12'h000, 4, "R9 mode a10 set");
    step(1, P_MRS, 2, 12'h000, 1, 9, 12'h000, 12'h000, 4, "R9 mode bank set");
    step(1, P_REF, 0, 12'h000, 1, 10, 12'h000, 12'h000, 0, "R10 refresh idle");
    step(0, P_ACT, 0, 12'h111, 0, 0, 12'h000, 12'h000, 0, "R1 cke low");
    step(1, P_ACT, 0, 12'h111, 0, 0, 12'h000, 12'h000, 0, "R1 cke low previous");
    step(1, P_ACT, 0, 12'h222, 1, 6, 12'h222, 12'h000, 0, "R1 bank0 untouched");
    step(1, P_RD, 0, 12'h409, 1, 3, 12'h009, 12'h222, 0, "R4 read auto precharge");
    step(1, P_NOP, 0, 12'h000, 1, 0, 12'h000, 12'h000, 0, "R7 wait");
    step(1, P_NOP, 0, 12'h000, 1, 0, 12'h000, 12'h000, 0, "R7 wait");
    step(1, P_NOP, 0, 12'h000, 1, 0, 12'h000, 12'h000, 0, "R7 wait");
    step(1, P_ACT, 0, 12'h333, 1, 6, 12'h333, 12'h000, 2, "R7 activate at delay");
    step(1, P_ACT, 0, 12'h333, 1, 6, 12'h333, 12'h000, 0, "R7 activate after delay");
    step(1, P_WR, 3, 12'h400, 1, 5, 12'h000, 12'h000, 1, "R6 write auto closed bank");
    step(1, P_ACT, 3, 12'h777, 1, 6, 12'h777, 12'h000, 0, "R5 activate bank3");
    step(1, P_WR, 3, 12'h401, 1, 5, 12'h001, 12'h777, 0, "R4 write auto precharge");
    step(1, P_MRS, 0, 12'h000, 1, 9, 12'h000, 12'h000, 3, "R9 mode while closing");
    step(1, P_NOP, 0, 12'h000, 1, 0, 12'h000, 12'h000, 0, "R11 pulse ends");

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule